// File: doc/BRIEF.md
# Parallel ATA Device Probe and Soft-Reset Sequencer

This block runs the bring-up sequence of a parallel ATA channel. It has no bus timing of its own. It issues single register reads and writes to a PIO cycle engine through a request/acknowledge port, and the engine generates the chip selects, strobes and wait states. After a start pulse the sequencer checks each of the two possible devices with a write/read-back test on two taskfile registers. It then pulses the software reset bit in the device control register, waits for the devices to leave busy, and ends with a fixed run of device selections. The device 1 check happens only when the channel allows a slave.

When the sequence finishes, the block reports a two-bit presence mask and raises `done`. If a device stays busy past a deadline, the block sets `error` as well. Every delay is a clock-count parameter, so the integrator sets each one from the clock frequency.

Register addresses on `acc_addr` use four bits. Bit 3 selects the control block. Bits 2:0 give the register index. The sequencer uses these addresses: sector count 0x2, LBA low 0x3, device 0x6, status 0x7, device control 0xE.

Top module: `ata_probe_seq`

## Requirements
- R1: After reset, `done`, `error`, `busy`, `acc_req` and `present` are all 0.
- R2: Every write to the device register (0x6) carries 0xA0 to select device 0, or 0xB0 (0xA0 with bit 4 set) to select device 1.
- R3: The check of a device is one select write followed by six writes in this order: 0x55 to 0x2, 0xAA to 0x3, 0xAA to 0x2, 0x55 to 0x3, 0x55 to 0x2, 0xAA to 0x3. A read of 0x2 and then a read of 0x3 follow.
- R4: A device is marked present only if the read-back returns 0x55 from 0x2 and 0xAA from 0x3. Present bit 0 belongs to device 0 and bit 1 to device 1.
- R5: When `slave_ok` is 0 at start, device 1 is never checked or selected, and `present[1]` stays 0.
- R6: After the checks, device 0 is selected. The block then writes three values to 0xE: `ctl_base` with bit 2 cleared, the same value with bit 2 set, and the cleared value again. Each write completes at least SRST_CYC cycles after the previous one.
- R7: The first status read (0x7) completes at least SETTLE_CYC cycles after the last control write. Status reads repeat until bit 7 reads 0.
- R8: If device 1 is present, the block selects it and reads 0x2 and 0x3 up to twice. It stops early when both read 1, and it waits at least GAP_CYC cycles between the two reads. It then polls status until bit 7 reads 0.
- R9: At the end, the block selects device 0, then device 1 if present, then device 0 again if device 0 is present.
- R10: A status read of 0xFF clears the presence bit of the device being waited on, ends that wait, and does not set `error`.
- R11: If bit 7 of status is still set DEADLINE_CYC cycles after the last control write, the block sets `error` and `done` and issues no further access.
- R12: `acc_req` stays high, with address, data and direction stable, until the cycle in which `acc_ack` is sampled. Only one access is outstanding at a time.
- R13: `start` is ignored while `busy` is 1. `done` stays high until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Pulse that begins a sequence when the block is idle or done |
| slave_ok | input | 1 | Allows the device 1 check; latched at start |
| ctl_base | input | 8 | Device control value used for the reset pulse (bit 2 is overridden) |
| acc_req | output | 1 | Register access request to the PIO engine |
| acc_we | output | 1 | 1 for a write access, 0 for a read access |
| acc_addr | output | 4 | Bit 3 selects the control block; bits 2:0 give the register index |
| acc_wdata | output | 8 | Write data |
| acc_ack | input | 1 | One-cycle completion pulse from the PIO engine |
| acc_rdata | input | 8 | Read data, valid with `acc_ack` |
| present | output | 2 | Presence mask: bit 0 for device 0, bit 1 for device 1 |
| busy | output | 1 | A sequence is running |
| done | output | 1 | The sequence has ended; held until the next start |
| error | output | 1 | A device stayed busy past the deadline |

## Verification
A wrong step in the sequence shows up as a wrong address or data value in the write stream, or as a missing or extra write. The PIO engine sees this at the acknowledge of the access concerned, so the write log exposes the error within a few cycles of where it occurs. A wrong presence decision shows up later: in the mask at `done`, and in the device selections at the end of the sequence that depend on it. A delay counter that ends too early shows up as a shortened gap between the acknowledge cycles of the control writes, of the settle and status read, or of the two signature reads. A broken deadline path turns into an error flag that is missing or appears when it should not.

// File: rtl/ata_probe_pkg.sv
package ata_probe_pkg;

   localparam logic [3:0] A_NSECT = 4'h2;
   localparam logic [3:0] A_LBAL  = 4'h3;
   localparam logic [3:0] A_DEV   = 4'h6;
   localparam logic [3:0] A_STAT  = 4'h7;
   localparam logic [3:0] A_CTL   = 4'hE;

   localparam logic [7:0] SEL_D0   = 8'hA0;
   localparam logic [7:0] SEL_D1   = 8'hB0;
   localparam logic [7:0] SRST_BIT = 8'h04;
   localparam logic [7:0] PAT_LO   = 8'h55;
   localparam logic [7:0] PAT_HI   = 8'hAA;
   localparam logic [7:0] FLOAT_V  = 8'hFF;
   localparam logic [7:0] SIG_ONE  = 8'h01;
   localparam int         BSY_POS  = 7;
   localparam int         NPAT     = 6;

   typedef enum logic [4:0] {
      ST_IDLE, ST_SEL, ST_PAT, ST_RDN, ST_RDL, ST_SEL0,
      ST_C0, ST_W0, ST_C1, ST_W1, ST_C2, ST_SETTLE, ST_POLL0,
      ST_SEL1, ST_RN1, ST_RL1, ST_GAP, ST_POLL1,
      ST_F0, ST_F1, ST_F2, ST_DONE
   } seq_state_t;

   // test pattern data for step n of a device check
   function automatic logic [7:0] pat_data(input logic [2:0] n);
      case (n)
         3'd0, 3'd3, 3'd4: pat_data = PAT_LO;
         default:          pat_data = PAT_HI;
      endcase
   endfunction

   // even steps hit sector count, odd steps LBA low
   function automatic logic [3:0] pat_addr(input logic [2:0] n);
      pat_addr = n[0] ? A_LBAL : A_NSECT;
   endfunction

endpackage

// File: rtl/ata_seq_timer.sv
module ata_seq_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] val,
   output logic         expired
);

   generate
      if (W < 1) begin : g_bad_w
         $error("ata_seq_timer: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0) && !load;

endmodule

// File: rtl/ata_bus_access.sv
module ata_bus_access (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic       we,
   input  logic [3:0] addr,
   input  logic [7:0] wdata,
   output logic       acc_req,
   output logic       acc_we,
   output logic [3:0] acc_addr,
   output logic [7:0] acc_wdata,
   input  logic       acc_ack,
   input  logic [7:0] acc_rdata,
   output logic       fin,
   output logic [7:0] rdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_req   <= 1'b0;
         acc_we    <= 1'b0;
         acc_addr  <= '0;
         acc_wdata <= '0;
         fin       <= 1'b0;
         rdata     <= '0;
      end else begin
         fin <= 1'b0;
         if (go) begin
            acc_req   <= 1'b1;
            acc_we    <= we;
            acc_addr  <= addr;
            acc_wdata <= wdata;
         end else if (acc_req && acc_ack) begin
            acc_req <= 1'b0;
            fin     <= 1'b1;
            rdata   <= acc_rdata;
         end
      end
   end

   // R12: request held stable until acknowledged
   a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      acc_req && !acc_ack |=> acc_req && $stable(acc_addr) && $stable(acc_wdata) && $stable(acc_we));

   // R12: never a second request while one is outstanding
   a_r12_single: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> !acc_req);

endmodule

// File: rtl/ata_probe_seq.sv
module ata_probe_seq
   import ata_probe_pkg::*;
#(
   parameter int SRST_CYC     = 2000,
   parameter int SETTLE_CYC   = 200,
   parameter int GAP_CYC      = 5000,
   parameter int DEADLINE_CYC = 3000000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       slave_ok,
   input  logic [7:0] ctl_base,
   output logic       acc_req,
   output logic       acc_we,
   output logic [3:0] acc_addr,
   output logic [7:0] acc_wdata,
   input  logic       acc_ack,
   input  logic [7:0] acc_rdata,
   output logic [1:0] present,
   output logic       busy,
   output logic       done,
   output logic       error
);

   localparam int WAIT_MAX = (SRST_CYC > SETTLE_CYC)
                             ? ((SRST_CYC > GAP_CYC) ? SRST_CYC : GAP_CYC)
                             : ((SETTLE_CYC > GAP_CYC) ? SETTLE_CYC : GAP_CYC);
   localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
   localparam int DL_W     = $clog2(DEADLINE_CYC + 1);

   generate
      if (SRST_CYC < 1 || SETTLE_CYC < 1 || GAP_CYC < 1) begin : g_bad_wait
         $error("ata_probe_seq: every wait must be at least one cycle");
      end
      if (DEADLINE_CYC < 2) begin : g_bad_deadline
         $error("ata_probe_seq: DEADLINE_CYC must be at least 2");
      end
   endgenerate

   seq_state_t      state;
   logic            pend;
   logic            dsel;
   logic [2:0]      idx;
   logic            tries;
   logic [7:0]      nsect_v;
   logic            slave_en;
   logic            dl_run;

   logic            op_acc, op_wait, op_we;
   logic [3:0]      op_addr;
   logic [7:0]      op_wdata;
   logic [WAIT_W-1:0] op_wval;
   logic            go, fin, tmr_exp, dl_exp, step, in_dl, abort, dl_load;
   logic [7:0]      rd;
   logic [7:0]      ctl_clr;

   assign ctl_clr = ctl_base & ~SRST_BIT;

   always_comb begin
      op_acc   = 1'b0;
      op_wait  = 1'b0;
      op_we    = 1'b0;
      op_addr  = A_DEV;
      op_wdata = SEL_D0;
      op_wval  = WAIT_W'(SRST_CYC);
      case (state)
         ST_SEL:   begin op_acc = 1'b1; op_we = 1'b1; op_wdata = dsel ? SEL_D1 : SEL_D0; end
         ST_PAT:   begin op_acc = 1'b1; op_we = 1'b1; op_addr = pat_addr(idx); op_wdata = pat_data(idx); end
         ST_RDN, ST_RN1: begin op_acc = 1'b1; op_addr = A_NSECT; end
         ST_RDL, ST_RL1: begin op_acc = 1'b1; op_addr = A_LBAL; end
         ST_SEL0, ST_F0, ST_F2: begin op_acc = 1'b1; op_we = 1'b1; op_wdata = SEL_D0; end
         ST_SEL1, ST_F1: begin op_acc = 1'b1; op_we = 1'b1; op_wdata = SEL_D1; end
         ST_C0, ST_C2: begin op_acc = 1'b1; op_we = 1'b1; op_addr = A_CTL; op_wdata = ctl_clr; end
         ST_C1:    begin op_acc = 1'b1; op_we = 1'b1; op_addr = A_CTL; op_wdata = ctl_clr | SRST_BIT; end
         ST_POLL0, ST_POLL1: begin op_acc = 1'b1; op_addr = A_STAT; end
         ST_W0, ST_W1: op_wait = 1'b1;
         ST_SETTLE: begin op_wait = 1'b1; op_wval = WAIT_W'(SETTLE_CYC); end
         ST_GAP:    begin op_wait = 1'b1; op_wval = WAIT_W'(GAP_CYC); end
         default: ;
      endcase
   end

   assign in_dl   = (state == ST_SETTLE) || (state == ST_POLL0) || (state == ST_SEL1) ||
                    (state == ST_RN1) || (state == ST_RL1) || (state == ST_GAP) ||
                    (state == ST_POLL1);
   assign abort   = dl_run && dl_exp && in_dl && !acc_req;
   assign go      = op_acc && !pend && !abort;
   assign step    = op_acc ? fin : (op_wait && pend && tmr_exp);
   assign dl_load = (state == ST_C2) && step;
   assign busy    = (state != ST_IDLE) && (state != ST_DONE);

   ata_bus_access u_acc (
      .clk(clk), .rst_n(rst_n), .go(go), .we(op_we), .addr(op_addr), .wdata(op_wdata),
      .acc_req(acc_req), .acc_we(acc_we), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
      .acc_ack(acc_ack), .acc_rdata(acc_rdata), .fin(fin), .rdata(rd)
   );

   ata_seq_timer #(.W(WAIT_W)) u_wait (
      .clk(clk), .rst_n(rst_n), .load(op_wait && !pend), .val(op_wval), .expired(tmr_exp)
   );

   ata_seq_timer #(.W(DL_W)) u_deadline (
      .clk(clk), .rst_n(rst_n), .load(dl_load), .val(DL_W'(DEADLINE_CYC)), .expired(dl_exp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         pend     <= 1'b0;
         dsel     <= 1'b0;
         idx      <= '0;
         tries    <= 1'b0;
         nsect_v  <= '0;
         slave_en <= 1'b0;
         dl_run   <= 1'b0;
         present  <= '0;
         done     <= 1'b0;
         error    <= 1'b0;
      end else if (start && !busy) begin
         state    <= ST_SEL;
         pend     <= 1'b0;
         dsel     <= 1'b0;
         idx      <= '0;
         tries    <= 1'b0;
         slave_en <= slave_ok;
         dl_run   <= 1'b0;
         present  <= '0;
         done     <= 1'b0;
         error    <= 1'b0;
      end else if (abort) begin
         state  <= ST_DONE;
         pend   <= 1'b0;
         dl_run <= 1'b0;
         error  <= 1'b1;
         done   <= 1'b1;
      end else begin
         if (go || (op_wait && !pend)) pend <= 1'b1;
         if (dl_load) dl_run <= 1'b1;
         if (step) begin
            pend <= 1'b0;
            case (state)
               ST_SEL:  begin idx <= '0; state <= ST_PAT; end
               ST_PAT:  begin
                  if (idx == 3'(NPAT - 1)) state <= ST_RDN;
                  else idx <= idx + 1'b1;
               end
               ST_RDN:  begin nsect_v <= rd; state <= ST_RDL; end
               ST_RDL:  begin
                  present[dsel] <= (nsect_v == PAT_LO) && (rd == PAT_HI);
                  if (!dsel && slave_en) begin
                     dsel  <= 1'b1;
                     state <= ST_SEL;
                  end else begin
                     state <= ST_SEL0;
                  end
               end
               ST_SEL0:   state <= ST_C0;
               ST_C0:     state <= ST_W0;
               ST_W0:     state <= ST_C1;
               ST_C1:     state <= ST_W1;
               ST_W1:     state <= ST_C2;
               ST_C2:     state <= ST_SETTLE;
               ST_SETTLE: state <= ST_POLL0;
               ST_POLL0:  begin
                  if (rd == FLOAT_V) begin
                     present[0] <= 1'b0;
                     state <= present[1] ? ST_SEL1 : ST_F0;
                  end else if (!rd[BSY_POS]) begin
                     state <= present[1] ? ST_SEL1 : ST_F0;
                  end
               end
               ST_SEL1:   begin tries <= 1'b0; state <= ST_RN1; end
               ST_RN1:    begin nsect_v <= rd; state <= ST_RL1; end
               ST_RL1:    begin
                  if ((nsect_v == SIG_ONE && rd == SIG_ONE) || tries) begin
                     state <= ST_POLL1;
                  end else begin
                     tries <= 1'b1;
                     state <= ST_GAP;
                  end
               end
               ST_GAP:    state <= ST_RN1;
               ST_POLL1:  begin
                  if (rd == FLOAT_V) begin
                     present[1] <= 1'b0;
                     state <= ST_F0;
                     dl_run <= 1'b0;
                  end else if (!rd[BSY_POS]) begin
                     state <= ST_F0;
                     dl_run <= 1'b0;
                  end
               end
               ST_F0: begin
                  if (present[1])      state <= ST_F1;
                  else if (present[0]) state <= ST_F2;
                  else begin state <= ST_DONE; done <= 1'b1; end
               end
               ST_F1: begin
                  if (present[0]) state <= ST_F2;
                  else begin state <= ST_DONE; done <= 1'b1; end
               end
               ST_F2: begin state <= ST_DONE; done <= 1'b1; end
               default: ;
            endcase
         end
      end
   end

   // R11: an error always ends the sequence
   a_r11_err_done: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> done && !busy);

   // R2: device register only ever receives the two select codes
   a_r2_sel_code: assert property (@(posedge clk) disable iff (!rst_n)
      acc_req && acc_we && acc_addr == A_DEV |-> acc_wdata == SEL_D0 || acc_wdata == SEL_D1);

   // R5: no device 1 select when the slave is not allowed
   a_r5_no_dev1: assert property (@(posedge clk) disable iff (!rst_n)
      !slave_en |-> !(acc_req && acc_we && acc_addr == A_DEV && acc_wdata == SEL_D1) && !present[1]);

   // R6: control writes carry only the base value with bit 2 cleared or set
   a_r6_ctl_values: assert property (@(posedge clk) disable iff (!rst_n)
      acc_req && acc_we && acc_addr == A_CTL |-> (acc_wdata & ~SRST_BIT) == ctl_clr);

   // R13: done holds until a new start
   a_r13_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> done);

   // R11: no access is issued after done
   a_r11_quiet_done: assert property (@(posedge clk) disable iff (!rst_n)
      done && !acc_req |=> !acc_req || $rose(busy) || busy);

endmodule

// File: tb/tb_ata_probe_seq.sv
`timescale 1ns/1ps
module tb_ata_probe_seq;

   localparam int SRST_T = 20;
   localparam int SETL_T = 30;
   localparam int GAP_T  = 10;
   localparam int DL_T   = 400;

   // [8] slave_ok [7] dev0 fitted [6] dev1 fitted [5] dev1 signature ok
   // [4] dev0 stuck busy [3] dev1 stuck busy [2:1] mask [0] error
   localparam logic [8:0] VECS [8] = '{
      9'b1_1_1_1_0_0_11_0,
      9'b1_1_0_1_0_0_01_0,
      9'b0_1_1_1_0_0_01_0,
      9'b1_0_1_1_0_0_10_0,
      9'b0_0_0_1_0_0_00_0,
      9'b1_1_1_0_0_0_11_0,
      9'b1_1_1_1_1_0_11_1,
      9'b1_1_1_1_0_1_11_1
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic slave_ok = 1'b0;
   logic [7:0] ctl_base = 8'h0E;
   logic acc_req, acc_we;
   logic [3:0] acc_addr;
   logic [7:0] acc_wdata;
   logic acc_ack;
   logic [7:0] acc_rdata;
   logic [1:0] present;
   logic busy, done, error;

   always #2.5 clk = ~clk;

   ata_probe_seq #(.SRST_CYC(SRST_T), .SETTLE_CYC(SETL_T), .GAP_CYC(GAP_T),
                   .DEADLINE_CYC(DL_T)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .slave_ok(slave_ok), .ctl_base(ctl_base),
      .acc_req(acc_req), .acc_we(acc_we), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
      .acc_ack(acc_ack), .acc_rdata(acc_rdata), .present(present), .busy(busy),
      .done(done), .error(error)
   );

   // ---------------- PIO engine and device model ----------------
   logic cfg_ok0 = 1'b0, cfg_ok1 = 1'b0, cfg_sig1 = 1'b1, cfg_long0 = 1'b0, cfg_long1 = 1'b0;
   logic log_clr = 1'b0;
   int   cyc = 0;
   int   nlog = 0;
   logic [3:0] log_a [64];
   logic [7:0] log_d [64];
   int   log_c [64];
   int   stat_c = -1;
   int   n1 = 0;
   int   n1c [2];
   logic post = 1'b0;
   logic sel = 1'b0;
   logic [7:0] last_ctl = 8'h00;
   logic [7:0] ns [2];
   logic [7:0] lb [2];
   int   bcnt [2];
   logic in_svc = 1'b0;
   int   lat = 0;

   initial begin
      acc_ack = 1'b0;
      acc_rdata = 8'h00;
      ns[0] = 8'h00; ns[1] = 8'h00; lb[0] = 8'h00; lb[1] = 8'h00;
      bcnt[0] = 0; bcnt[1] = 0; n1c[0] = 0; n1c[1] = 0;
   end

   function automatic logic dev_ok(input logic d);
      return d ? cfg_ok1 : cfg_ok0;
   endfunction

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (bcnt[0] > 0) bcnt[0] <= bcnt[0] - 1;
      if (bcnt[1] > 0) bcnt[1] <= bcnt[1] - 1;
      acc_ack <= 1'b0;
      if (log_clr) begin
         nlog <= 0; post <= 1'b0; n1 <= 0; stat_c <= -1; last_ctl <= 8'h00;
         sel <= 1'b0; in_svc <= 1'b0;
      end else if (acc_req && !acc_ack) begin
         if (!in_svc) begin
            in_svc <= 1'b1;
            lat <= 2;
         end else if (lat != 0) begin
            lat <= lat - 1;
         end else begin
            in_svc <= 1'b0;
            acc_ack <= 1'b1;
            if (acc_we) begin
               if (nlog < 64) begin
                  log_a[nlog] <= acc_addr; log_d[nlog] <= acc_wdata; log_c[nlog] <= cyc;
                  nlog <= nlog + 1;
               end
               case (acc_addr)
                  4'h6: sel <= acc_wdata[4];
                  4'h2: if (dev_ok(sel)) ns[sel] <= acc_wdata;
                  4'h3: if (dev_ok(sel)) lb[sel] <= acc_wdata;
                  4'hE: begin
                     if (last_ctl[2] && !acc_wdata[2]) begin
                        post <= 1'b1;
                        if (cfg_ok0) begin
                           bcnt[0] <= cfg_long0 ? 100000 : 50; ns[0] <= 8'h01; lb[0] <= 8'h01;
                        end
                        if (cfg_ok1) begin
                           bcnt[1] <= cfg_long1 ? 100000 : 50;
                           ns[1] <= cfg_sig1 ? 8'h01 : 8'h00; lb[1] <= cfg_sig1 ? 8'h01 : 8'h00;
                        end
                     end
                     last_ctl <= acc_wdata;
                  end
                  default: ;
               endcase
            end else begin
               if (!dev_ok(sel)) acc_rdata <= 8'hFF;
               else case (acc_addr)
                  4'h2: acc_rdata <= ns[sel];
                  4'h3: acc_rdata <= lb[sel];
                  4'h7: acc_rdata <= (bcnt[sel] != 0) ? 8'h80 : 8'h50;
                  default: acc_rdata <= 8'h00;
               endcase
               if (acc_addr == 4'h7 && post && stat_c < 0) stat_c <= cyc;
               if (acc_addr == 4'h2 && post) begin
                  if (n1 < 2) n1c[n1] <= cyc;
                  n1 <= n1 + 1;
               end
            end
         end
      end
   end

   // ---------------- checking ----------------
   int nchk = 0;
   int nerr = 0;
   bit finished = 1'b0;
   logic [3:0] ex_a [64];
   logic [7:0] ex_d [64];
   int ex_n;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic add_w(input logic [3:0] a, input logic [7:0] d);
      ex_a[ex_n] = a; ex_d[ex_n] = d; ex_n++;
   endtask

   task automatic build_exp(input logic [8:0] v);
      logic p0, p1;
      ex_n = 0;
      for (int d = 0; d < 2; d++) begin
         if (d == 0 || v[8]) begin
            add_w(4'h6, d ? 8'hB0 : 8'hA0);
            add_w(4'h2, 8'h55); add_w(4'h3, 8'hAA); add_w(4'h2, 8'hAA);
            add_w(4'h3, 8'h55); add_w(4'h2, 8'h55); add_w(4'h3, 8'hAA);
         end
      end
      add_w(4'h6, 8'hA0);
      add_w(4'hE, 8'h0A); add_w(4'hE, 8'h0E); add_w(4'hE, 8'h0A);
      p0 = v[7];
      p1 = v[8] && v[6];
      if (!v[4]) begin
         if (p1) add_w(4'h6, 8'hB0);
         if (!(p1 && v[3])) begin
            add_w(4'h6, 8'hA0);
            if (p1) add_w(4'h6, 8'hB0);
            if (p0) add_w(4'h6, 8'hA0);
         end
      end
   endtask

   task automatic kick(input logic sl);
      @(negedge clk);
      slave_ok = sl; start = 1'b1; log_clr = 1'b1;
      @(negedge clk);
      start = 1'b0; log_clr = 1'b0;
   endtask

   task automatic wait_done();
      for (int i = 0; i < 4000; i++) begin
         if (done) break;
         @(negedge clk);
      end
   endtask

   task automatic run_vec(input int k, input logic [8:0] v);
      int probes, cbase, exp_rd;
      bit seq_ok;
      cfg_ok0 = v[7]; cfg_ok1 = v[6]; cfg_sig1 = v[5]; cfg_long0 = v[4]; cfg_long1 = v[3];
      kick(v[8]);
      wait_done();
      chk(done == 1'b1, $sformatf("R13 done v%0d", k), done, 1);
      chk(present == v[2:1], $sformatf("R4 R5 R10 mask v%0d", k), present, v[2:1]);
      chk(error == v[0], $sformatf("R11 R10 error v%0d", k), error, v[0]);
      build_exp(v);
      chk(nlog == ex_n, $sformatf("R9 write count v%0d", k), nlog, ex_n);
      seq_ok = 1'b1;
      for (int i = 0; i < ex_n && i < nlog; i++)
         if (log_a[i] != ex_a[i] || log_d[i] != ex_d[i]) seq_ok = 1'b0;
      chk(seq_ok, $sformatf("R2 R3 R6 R9 write sequence v%0d", k), seq_ok, 1);
      probes = v[8] ? 2 : 1;
      cbase = probes * 7 + 1;
      chk((log_c[cbase+1] - log_c[cbase] >= SRST_T) && (log_c[cbase+2] - log_c[cbase+1] >= SRST_T),
          $sformatf("R6 srst spacing v%0d", k), log_c[cbase+2] - log_c[cbase+1], SRST_T);
      chk(stat_c - log_c[cbase+2] >= SETL_T, $sformatf("R7 settle v%0d", k),
          stat_c - log_c[cbase+2], SETL_T);
      exp_rd = (!v[4] && v[8] && v[6]) ? (v[5] ? 1 : 2) : 0;
      chk(n1 == exp_rd, $sformatf("R8 signature reads v%0d", k), n1, exp_rd);
      if (exp_rd == 2)
         chk(n1c[1] - n1c[0] >= GAP_T, $sformatf("R8 poll gap v%0d", k), n1c[1] - n1c[0], GAP_T);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(done == 1'b0 && error == 1'b0 && busy == 1'b0, "R1 flags after reset",
          {done, error, busy}, 0);
      chk(acc_req == 1'b0 && present == 2'b00, "R1 port idle after reset", {acc_req, present}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int k = 0; k < 8; k++) run_vec(k, VECS[k]);

      // R13: restart clears done; a start while busy is ignored
      cfg_ok0 = 1'b1; cfg_ok1 = 1'b1; cfg_sig1 = 1'b1; cfg_long0 = 1'b0; cfg_long1 = 1'b0;
      kick(1'b1);
      chk(done == 1'b0 && busy == 1'b1, "R13 done cleared by start", {done, busy}, 1);
      repeat (60) @(negedge clk);
      slave_ok = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R13 still busy after ignored start", busy, 1);
      wait_done();
      build_exp(VECS[0]);
      chk(present == 2'b11 && error == 1'b0, "R13 ignored start left mask", present, 3);
      chk(nlog == ex_n, "R13 ignored start left write stream", nlog, ex_n);

      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

endmodule